// File: doc/BRIEF.md
# Command-Queue Execution Thread

This block is a single execution thread of a command-queue engine. Software loads a start address and an end address into its register window and sets the enable bit. The thread then reads 64-bit instructions from memory through a request/response fetch port and advances a program counter until it reaches the end address. It holds at most one fetched instruction ahead of execution. It understands relative jumps, absolute jumps and a wait-for-event stall. Every other opcode is a no-operation.

Software can freeze the thread at any time with a suspend request. Once the status register reports the thread as suspended, software can move the program counter or the end address. Any write to the program counter throws away the prefetched instruction and any fetch still in flight, even when the written value is unchanged. Done, fetch-error and jump-alignment-error flags collect in an interrupt status register. The interrupt pin is raised when any flag is set whose enable bit is also set.

Top module: `cmdseq_thread`

## Requirements
- R1: After reset these registers read zero: enable, suspend, status, interrupt status, interrupt enable, program counter, end address, wait token and priority. The irq pin and fetch_req_valid are low after reset.
- R2: When enabled, each instruction that is not a jump or a wait advances the program counter by 8. Each executed instruction is fetched once, in address order. When the counter equals the end address, status bit 0 of the interrupt status register (offset 0x10) is set and the thread stops.
- R3: An instruction whose upper word is 0x10000000 adds its lower word to the program counter, modulo 2^32. An instruction whose upper word is 0x10000001 loads its lower word into the program counter. A jump that lands on the end address sets the done bit.
- R4: A jump whose target has any of bits 2..0 set does not move the program counter. It sets interrupt status bit 4, and the thread stops until that bit is cleared.
- R5: An instruction whose upper byte (bits 63..56) is 0x20 stalls the thread, and bit 31 of the wait-token register (offset 0x30) reads 1. A one-cycle pulse on wake_evt during the stall advances the program counter by 8. A pulse that arrives while no wait is pending has no effect.
- R6: Writing 1 to the suspend register (offset 0x08) stops all new fetches and execution. Status bit 1 (offset 0x0C) reads 1 once no fetch is pending, and the program counter then stays unchanged. The end address may be raised while suspended. Writing 0 resumes the thread.
- R7: Any write to the program counter (offset 0x20), including a write of its current value, discards the prefetched instruction and any fetch still in flight. Fetching restarts from the written address.
- R8: A fetch response with fetch_rsp_err high sets interrupt status bit 1 and does not move the program counter. The thread stops until that bit is cleared, and then refetches from the same address.
- R9: In a write to the interrupt status register, a 0 bit clears that flag and a 1 bit leaves it unchanged. The irq pin is high when any flag is set whose enable bit is also set in the register at offset 0x14.
- R10: Writing 1 to bit 0 of offset 0x00 starts a warm reset. The bit reads 1 in the following cycle and 0 after that. The warm reset clears enable, suspend, interrupt status and the prefetch. It keeps the program counter, end address, interrupt enable and priority.
- R11: fetch_req_valid is held high with a stable address until fetch_req_ready is high. At most one fetch is pending at a time. fetch_rsp_ready is high only while a response is owed.
- R12: The priority register (offset 0x40) keeps the low PRIO_W bits of a write. Reads return those bits, and the thread_prio output drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 7 | byte offset inside the 128-byte window |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr (combinational) |
| fetch_req_valid | output | 1 | fetch request valid |
| fetch_req_ready | input | 1 | memory accepts the request |
| fetch_req_addr | output | ADDR_W | byte address of the instruction |
| fetch_rsp_valid | input | 1 | response valid |
| fetch_rsp_ready | output | 1 | thread owes a response and takes it |
| fetch_rsp_data | input | 64 | instruction word |
| fetch_rsp_err | input | 1 | response carries an error |
| wake_evt | input | 1 | event pulse that releases a wait |
| irq | output | 1 | thread interrupt |
| thread_prio | output | PRIO_W | programmed priority |

## Verification
The hardest case to reach is a program-counter write that arrives while a fetch is still in flight or while a wait instruction sits in the prefetch slot. In that case the thread must throw away a response it has already asked for. The bench parks the thread on a wait instruction and rewrites the program counter with its own value. It then checks that the wait token drops, that exactly one extra fetch goes out, and that the thread stalls again. Separately, a sweep over response latency and ready gaps, with suspend requests placed mid-run, covers the in-flight window from the other side.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int REG_AW = 7;
  localparam logic [REG_AW-1:0] OFS_WRST = 7'h00;
  localparam logic [REG_AW-1:0] OFS_EN   = 7'h04;
  localparam logic [REG_AW-1:0] OFS_SUSP = 7'h08;
  localparam logic [REG_AW-1:0] OFS_STAT = 7'h0C;
  localparam logic [REG_AW-1:0] OFS_ISTS = 7'h10;
  localparam logic [REG_AW-1:0] OFS_IEN  = 7'h14;
  localparam logic [REG_AW-1:0] OFS_PC   = 7'h20;
  localparam logic [REG_AW-1:0] OFS_END  = 7'h24;
  localparam logic [REG_AW-1:0] OFS_WAIT = 7'h30;
  localparam logic [REG_AW-1:0] OFS_PRIO = 7'h40;

  localparam int IRQ_W    = 5;
  localparam int IRQ_DONE = 0;
  localparam int IRQ_FERR = 1;
  localparam int IRQ_JERR = 4;
  localparam logic [IRQ_W-1:0] IRQ_IMPL = 5'b10011;

  localparam logic [31:0] HI_JREL = 32'h1000_0000;
  localparam logic [31:0] HI_JABS = 32'h1000_0001;
  localparam logic [7:0]  WFE_OPC = 8'h20;
  localparam int INSTR_BYTES = 8;
  localparam int ALIGN_W     = $clog2(INSTR_BYTES);

  typedef enum logic [1:0] {OP_NOP, OP_JREL, OP_JABS, OP_WFE} op_e;
endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [63:0]       instr,
  input  logic [ADDR_W-1:0] pc,
  output op_e               op,
  output logic [ADDR_W-1:0] target,
  output logic              misaligned
);
  logic [31:0] hi;
  logic [ADDR_W-1:0] lo;

  always_comb begin
    hi = instr[63:32];
    lo = instr[ADDR_W-1:0];
    if (hi == HI_JREL)               op = OP_JREL;
    else if (hi == HI_JABS)          op = OP_JABS;
    else if (hi[31:24] == WFE_OPC)   op = OP_WFE;
    else                             op = OP_NOP;
    target     = (op == OP_JREL) ? pc + lo : lo;
    misaligned = ((op == OP_JREL) || (op == OP_JABS)) && (target[ALIGN_W-1:0] != '0);
  end
endmodule

// File: rtl/cmdseq_fetch.sv
module cmdseq_fetch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              issue_ok,
  input  logic [ADDR_W-1:0] pc,
  input  logic              consume,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [63:0]       rsp_data,
  input  logic              rsp_err,
  output logic              buf_valid,
  output logic [63:0]       buf_data,
  output logic              idle,
  output logic              err_pulse
);
  logic              req_q, owed_q, drop_q, buf_q;
  logic [ADDR_W-1:0] addr_q;
  logic [63:0]       data_q;
  logic              rsp_take, discard;

  assign rsp_take  = rsp_valid & owed_q;
  assign discard   = drop_q | flush;
  assign err_pulse = rsp_take & ~discard & rsp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      owed_q <= 1'b0;
      drop_q <= 1'b0;
      buf_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (req_q && req_ready) begin
        req_q  <= 1'b0;
        owed_q <= 1'b1;
      end else if (!req_q && !owed_q && !buf_q && issue_ok && !flush) begin
        req_q  <= 1'b1;
        addr_q <= pc;
      end
      if (rsp_take) begin
        owed_q <= 1'b0;
        drop_q <= 1'b0;
        if (!discard && !rsp_err) begin
          buf_q  <= 1'b1;
          data_q <= rsp_data;
        end
      end else if (flush && (owed_q || req_q)) begin
        drop_q <= 1'b1;
      end
      if (flush || consume) buf_q <= 1'b0;
    end
  end

  assign req_valid = req_q;
  assign req_addr  = addr_q;
  assign rsp_ready = owed_q;
  assign buf_valid = buf_q;
  assign buf_data  = data_q;
  assign idle      = ~req_q & ~owed_q;
endmodule

// File: rtl/cmdseq_thread.sv
module cmdseq_thread
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              fetch_req_valid,
  input  logic              fetch_req_ready,
  output logic [ADDR_W-1:0] fetch_req_addr,
  input  logic              fetch_rsp_valid,
  output logic              fetch_rsp_ready,
  input  logic [63:0]       fetch_rsp_data,
  input  logic              fetch_rsp_err,
  input  logic              wake_evt,
  output logic              irq,
  output logic [PRIO_W-1:0] thread_prio
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic              en_q, susp_q, wrst_q;
  logic [IRQ_W-1:0]  ists_q, ien_q, ists_n, set_v;
  logic [ADDR_W-1:0] pc_q, end_q, npc, target;
  logic [PRIO_W-1:0] prio_q;

  logic wr_wrst, wr_en, wr_susp, wr_ists, wr_ien, wr_pc, wr_end, wr_prio;
  logic run, at_end, flush, issue_ok, exec_ok, is_jump, jerr, step, done_set;
  logic buf_v, fetch_idle, ferr, misaligned, wait_tok;
  logic [63:0] buf_d;
  op_e op;

  assign wr_wrst = reg_wr && (reg_addr == OFS_WRST);
  assign wr_en   = reg_wr && (reg_addr == OFS_EN);
  assign wr_susp = reg_wr && (reg_addr == OFS_SUSP);
  assign wr_ists = reg_wr && (reg_addr == OFS_ISTS);
  assign wr_ien  = reg_wr && (reg_addr == OFS_IEN);
  assign wr_pc   = reg_wr && (reg_addr == OFS_PC);
  assign wr_end  = reg_wr && (reg_addr == OFS_END);
  assign wr_prio = reg_wr && (reg_addr == OFS_PRIO);

  assign run      = en_q & ~susp_q & ~ists_q[IRQ_FERR] & ~ists_q[IRQ_JERR];
  assign at_end   = (pc_q == end_q);
  assign flush    = wr_pc | wrst_q;
  assign issue_ok = run & ~at_end;

  cmdseq_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .issue_ok  (issue_ok),
    .pc        (pc_q),
    .consume   (step),
    .req_valid (fetch_req_valid),
    .req_ready (fetch_req_ready),
    .req_addr  (fetch_req_addr),
    .rsp_valid (fetch_rsp_valid),
    .rsp_ready (fetch_rsp_ready),
    .rsp_data  (fetch_rsp_data),
    .rsp_err   (fetch_rsp_err),
    .buf_valid (buf_v),
    .buf_data  (buf_d),
    .idle      (fetch_idle),
    .err_pulse (ferr)
  );

  cmdseq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .instr      (buf_d),
    .pc         (pc_q),
    .op         (op),
    .target     (target),
    .misaligned (misaligned)
  );

  assign exec_ok  = buf_v & run & ~at_end & ~flush;
  assign is_jump  = (op == OP_JREL) || (op == OP_JABS);
  assign jerr     = exec_ok & is_jump & misaligned;
  assign step     = exec_ok & ~jerr & ((op != OP_WFE) | wake_evt);
  assign npc      = is_jump ? target : pc_q + STEP;
  assign done_set = step & (npc == end_q);
  assign wait_tok = en_q & buf_v & (op == OP_WFE);

  always_comb begin
    set_v           = '0;
    set_v[IRQ_DONE] = done_set;
    set_v[IRQ_FERR] = ferr;
    set_v[IRQ_JERR] = jerr;
  end

  for (genvar b = 0; b < IRQ_W; b++) begin : g_ists
    if (IRQ_IMPL[b]) begin : g_impl
      assign ists_n[b] = ~wrst_q & ((ists_q[b] & ~(wr_ists & ~reg_wdata[b])) | set_v[b]);
    end else begin : g_none
      assign ists_n[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      wrst_q <= 1'b0;
      ists_q <= '0;
      ien_q  <= '0;
      pc_q   <= '0;
      end_q  <= '0;
      prio_q <= '0;
    end else begin
      wrst_q <= wr_wrst & reg_wdata[0];
      ists_q <= ists_n;
      if (wrst_q)       en_q <= 1'b0;
      else if (wr_en)   en_q <= reg_wdata[0];
      if (wrst_q)       susp_q <= 1'b0;
      else if (wr_susp) susp_q <= reg_wdata[0];
      if (wr_pc)        pc_q <= reg_wdata[ADDR_W-1:0];
      else if (step)    pc_q <= npc;
      if (wr_end)       end_q <= reg_wdata[ADDR_W-1:0];
      if (wr_ien)       ien_q <= reg_wdata[IRQ_W-1:0] & IRQ_IMPL;
      if (wr_prio)      prio_q <= reg_wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_WRST: reg_rdata = {31'b0, wrst_q};
      OFS_EN:   reg_rdata = {31'b0, en_q};
      OFS_SUSP: reg_rdata = {31'b0, susp_q};
      OFS_STAT: reg_rdata = {30'b0, susp_q & fetch_idle, run & ~at_end};
      OFS_ISTS: reg_rdata = 32'(ists_q);
      OFS_IEN:  reg_rdata = 32'(ien_q);
      OFS_PC:   reg_rdata = 32'(pc_q);
      OFS_END:  reg_rdata = 32'(end_q);
      OFS_WAIT: reg_rdata = {wait_tok, 31'b0};
      OFS_PRIO: reg_rdata = 32'(prio_q);
      default:  reg_rdata = 32'b0;
    endcase
  end

  assign irq         = |(ists_q & ien_q);
  assign thread_prio = prio_q;
endmodule

// File: rtl/cmdseq_thread_chk.sv
module cmdseq_thread_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_ready,
  input logic              en,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] end_addr,
  input logic              ferr_flag,
  input logic              done_flag,
  input logic              wrst,
  input logic              pc_write,
  input logic              wrst_write
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R11
  rsp_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_ready && !req_valid);

  // R2
  end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && (pc == end_addr) && !pc_write |=> $stable(pc));

  // R2
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) && $stable(end_addr) |-> pc == end_addr);

  // R8
  ferr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_flag && !pc_write |=> $stable(pc));

  // R10
  wrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrst && !wrst_write |=> !wrst);
endmodule

bind cmdseq_thread cmdseq_thread_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (fetch_req_valid),
  .req_ready  (fetch_req_ready),
  .req_addr   (fetch_req_addr),
  .rsp_ready  (fetch_rsp_ready),
  .en         (en_q),
  .pc         (pc_q),
  .end_addr   (end_q),
  .ferr_flag  (ists_q[1]),
  .done_flag  (ists_q[0]),
  .wrst       (wrst_q),
  .pc_write   (wr_pc),
  .wrst_write (wr_wrst)
);

// File: tb/cmdseq_thread_tb.sv
module cmdseq_thread_tb;
  import cmdseq_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, reg_wr, fetch_req_valid, fetch_req_ready, fetch_rsp_valid;
  logic        fetch_rsp_ready, fetch_rsp_err, wake_evt, irq;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, fetch_req_addr;
  logic [63:0] fetch_rsp_data;
  logic [3:0]  thread_prio;

  cmdseq_thread u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_req_addr(fetch_req_addr), .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_rsp_ready(fetch_rsp_ready), .fetch_rsp_data(fetch_rsp_data),
    .fetch_rsp_err(fetch_rsp_err), .wake_evt(wake_evt), .irq(irq),
    .thread_prio(thread_prio)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [63:0] mem [32];
  int lat = 0, gap = 0, err_idx = -1, hs = 0, tick = 0, cnt = 0, proto_bad = 0;
  logic [31:0] hs_addr [64];
  logic [31:0] pend_addr = '0, prev_addr = '0;
  bit pend = 0, rsp_acc = 0, prev_v = 0, prev_r = 0;

  localparam logic [63:0] WFE = 64'h2000_0000_0000_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model: drives inputs at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      tick++;
      if (prev_v && !prev_r && !(fetch_req_valid && fetch_req_addr == prev_addr)) proto_bad++;
      if (rsp_acc) begin
        fetch_rsp_valid = 1'b0;
        pend = 0;
      end
      if (fetch_rsp_ready && !pend) proto_bad++;
      if (fetch_req_valid && pend) proto_bad++;
      if (pend && !fetch_rsp_valid) begin
        if (cnt == 0) begin
          fetch_rsp_valid = 1'b1;
          fetch_rsp_data  = mem[pend_addr[7:3]];
          fetch_rsp_err   = (err_idx == int'(pend_addr[7:3]));
        end else cnt--;
      end
      fetch_req_ready = (gap == 0) || (tick % (gap + 1) == 0);
      if (fetch_req_valid && fetch_req_ready) begin
        pend = 1;
        pend_addr = fetch_req_addr;
        cnt = lat;
        if (hs < 64) hs_addr[hs] = fetch_req_addr;
        hs++;
      end
      rsp_acc = fetch_rsp_valid && fetch_rsp_ready;
      prev_v = fetch_req_valid;
      prev_r = fetch_req_ready;
      prev_addr = fetch_req_addr;
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_bits(input logic [6:0] a, input logic [31:0] m, input string req);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(a, v);
      if ((v & m) != 0) return;
      @(negedge clk);
    end
    chk(req, 32'hdead, m);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) mem[i] = 64'h0;
  endtask

  task automatic start(input logic [31:0] p, input logic [31:0] e);
    wr(OFS_EN, 0); wr(OFS_SUSP, 0); wr(OFS_ISTS, 0);
    wr(OFS_PC, p); wr(OFS_END, e);
    repeat (6) @(negedge clk);
    hs = 0;
    wr(OFS_EN, 1);
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, p0;
    int h0;
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0; wake_evt = 0;
    fetch_req_ready = 0; fetch_rsp_valid = 0; fetch_rsp_data = '0; fetch_rsp_err = 0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    foreach (hs_addr[i]) hs_addr[i] = '0;
    rd(OFS_EN, v);   chk("R1 en", v, 0);
    rd(OFS_SUSP, v); chk("R1 susp", v, 0);
    rd(OFS_STAT, v); chk("R1 stat", v, 0);
    rd(OFS_ISTS, v); chk("R1 ists", v, 0);
    rd(OFS_IEN, v);  chk("R1 ien", v, 0);
    rd(OFS_PC, v);   chk("R1 pc", v, 0);
    rd(OFS_END, v);  chk("R1 end", v, 0);
    rd(OFS_WAIT, v); chk("R1 wait", v, 0);
    rd(OFS_PRIO, v); chk("R1 prio", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 req_valid", 32'(fetch_req_valid), 0);

    // R2 sweep: length x ready gap x latency
    for (int n = 1; n <= 6; n++)
      for (int g = 0; g <= 2; g++)
        for (int l = 0; l <= 2; l++) begin
          gap = g; lat = l;
          start(0, 32'(8 * n));
          wait_bits(OFS_ISTS, 1, "R2 done");
          rd(OFS_PC, v);   chk("R2 pc at end", v, 32'(8 * n));
          rd(OFS_ISTS, v); chk("R2 ists", v, 1);
          rd(OFS_STAT, v); chk("R2 stat idle", v, 0);
          chk("R2 fetch count", 32'(hs), 32'(n));
          for (int i = 0; i < n; i++) chk("R2 fetch order", hs_addr[i], 32'(8 * i));
        end

    gap = 1; lat = 1;
    // R3 relative forward jump
    clear_mem(); mem[0] = {HI_JREL, 32'h18};
    start(0, 32'h20);
    wait_bits(OFS_ISTS, 1, "R3 rel done");
    rd(OFS_PC, v); chk("R3 rel pc", v, 32'h20);
    chk("R3 rel fetches", 32'(hs), 2); chk("R3 rel target", hs_addr[1], 32'h18);
    // R3 absolute jump
    clear_mem(); mem[0] = {HI_JABS, 32'h30};
    start(0, 32'h38);
    wait_bits(OFS_ISTS, 1, "R3 abs done");
    chk("R3 abs fetches", 32'(hs), 2); chk("R3 abs target", hs_addr[1], 32'h30);
    // R3 backward relative jump, landing on end
    clear_mem(); mem[5] = {HI_JREL, 32'hFFFF_FFE8};
    start(32'h28, 32'h10);
    wait_bits(OFS_ISTS, 1, "R3 back done");
    rd(OFS_PC, v); chk("R3 back pc", v, 32'h10);
    chk("R3 back fetches", 32'(hs), 1);

    // R4 misaligned jump
    clear_mem(); mem[0] = {HI_JABS, 32'h13};
    wr(OFS_IEN, 32'h13);
    start(0, 32'h40);
    wait_bits(OFS_ISTS, 32'h10, "R4 jerr");
    repeat (5) @(negedge clk);
    rd(OFS_ISTS, v); chk("R4 ists", v, 32'h10);
    rd(OFS_PC, v);   chk("R4 pc unchanged", v, 0);
    chk("R4 irq", 32'(irq), 1);

    // R5 wait for event, early pulse ignored
    clear_mem(); mem[2] = WFE;
    start(0, 32'h20);
    pulse_wake();
    wait_bits(OFS_WAIT, 32'h8000_0000, "R5 token");
    rd(OFS_PC, v); chk("R5 stalled pc", v, 32'h10);
    repeat (10) @(negedge clk);
    rd(OFS_ISTS, v); chk("R5 no done while stalled", v, 0);
    rd(OFS_PC, v);   chk("R5 pc held", v, 32'h10);
    pulse_wake();
    wait_bits(OFS_ISTS, 1, "R5 done");
    rd(OFS_PC, v); chk("R5 pc after wake", v, 32'h20);

    // R6 suspend, extend end, resume
    clear_mem(); gap = 1; lat = 2;
    start(0, 32'h40);
    repeat (6) @(negedge clk);
    wr(OFS_SUSP, 1);
    wait_bits(OFS_STAT, 2, "R6 suspended");
    rd(OFS_PC, p0); h0 = hs;
    rd(OFS_ISTS, v); chk("R6 not done", v, 0);
    repeat (15) @(negedge clk);
    rd(OFS_PC, v); chk("R6 pc frozen", v, p0);
    chk("R6 no fetch", 32'(hs), 32'(h0));
    wr(OFS_END, 32'hC0);
    repeat (5) @(negedge clk);
    rd(OFS_ISTS, v); chk("R6 still not done", v, 0);
    wr(OFS_SUSP, 0);
    wait_bits(OFS_ISTS, 1, "R6 done");
    rd(OFS_PC, v); chk("R6 pc extended end", v, 32'hC0);
    chk("R6 total fetches", 32'(hs), 24);

    // R7 program counter write discards prefetch
    clear_mem(); mem[0] = WFE; gap = 0; lat = 1;
    start(0, 32'h40);
    wait_bits(OFS_WAIT, 32'h8000_0000, "R7 stall");
    chk("R7 one fetch", 32'(hs), 1);
    wr(OFS_PC, 0);
    rd(OFS_WAIT, v); chk("R7 same-value write drops token", v, 0);
    wait_bits(OFS_WAIT, 32'h8000_0000, "R7 restall");
    chk("R7 refetch", 32'(hs), 2); chk("R7 refetch addr", hs_addr[1], 0);
    hs = 0;
    wr(OFS_PC, 32'h10);
    rd(OFS_WAIT, v); chk("R7 retarget drops token", v, 0);
    wait_bits(OFS_ISTS, 1, "R7 done");
    rd(OFS_PC, v); chk("R7 pc", v, 32'h40);
    chk("R7 fetches", 32'(hs), 6); chk("R7 first addr", hs_addr[0], 32'h10);

    // R8 fetch error, R9 status write and masking
    clear_mem(); err_idx = 1;
    start(0, 32'h20);
    wait_bits(OFS_ISTS, 2, "R8 ferr");
    repeat (5) @(negedge clk);
    rd(OFS_ISTS, v); chk("R8 ists", v, 2);
    rd(OFS_PC, v);   chk("R8 pc held", v, 8);
    chk("R8 fetches", 32'(hs), 2);
    chk("R8 irq", 32'(irq), 1);
    wr(OFS_IEN, 1);
    chk("R9 masked irq", 32'(irq), 0);
    wr(OFS_ISTS, 32'hFFFF_FFFF);
    rd(OFS_ISTS, v); chk("R9 ones keep", v, 2);
    err_idx = -1;
    wr(OFS_IEN, 32'h13);
    wr(OFS_ISTS, 32'hFFFF_FFFD);
    wait_bits(OFS_ISTS, 1, "R8 done after clear");
    rd(OFS_PC, v);   chk("R8 pc end", v, 32'h20);
    rd(OFS_ISTS, v); chk("R9 zero clears", v, 1);
    chk("R8 refetch count", 32'(hs), 5);
    chk("R9 irq done", 32'(irq), 1);

    // R10 warm reset
    wr(OFS_WRST, 1);
    rd(OFS_WRST, v); chk("R10 busy", v, 1);
    @(negedge clk);
    rd(OFS_WRST, v); chk("R10 self clear", v, 0);
    rd(OFS_EN, v);   chk("R10 en cleared", v, 0);
    rd(OFS_ISTS, v); chk("R10 ists cleared", v, 0);
    rd(OFS_PC, v);   chk("R10 pc kept", v, 32'h20);
    rd(OFS_END, v);  chk("R10 end kept", v, 32'h20);
    rd(OFS_IEN, v);  chk("R10 ien kept", v, 32'h13);

    // R12 priority
    wr(OFS_PRIO, 32'hFFFF_FFF5);
    rd(OFS_PRIO, v); chk("R12 prio read", v, 5);
    chk("R12 prio port", 32'(thread_prio), 5);

    // R11 protocol seen by the memory model over the whole run
    chk("R11 protocol violations", 32'(proto_bad), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule